// File: doc/BRIEF.md
# Banked Interrupt Collector with Per-Line Trigger Selection

This block gathers external interrupt lines in groups of 32, called banks, and raises one summary request per bank toward an upstream interrupt controller. The number of banks is a parameter; four and five are the configurations in use. Every line has its own trigger configuration. One bit chooses between level and edge sensing, and a second bit chooses the active sense: high or rising, or low or falling. Every line also has a mask bit, a software-raise bit and an acknowledge bit.

Software reaches the block through a simple synchronous port with byte addresses and one cycle of read latency. Each bank occupies 24 bytes. Banks follow one another without gaps, so bank `b` starts at byte `b*24`.

Every external line is first passed through a two-stage synchroniser. An edge-mode line then records a sticky pending bit when it sees its selected edge. A level-mode line reports its qualified level live. For each bank the block also shows, on dedicated output pins, the number of the highest enabled active line together with a valid flag.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Within bank `b`, the register at byte `b*24` is the status register. The following registers sit at `+4` enable, `+8` raise, `+12` acknowledge, `+16` sense and `+20` mode. Read data appears on `reg_rdata` one clock after the read is issued. An address at or beyond `NUM_BANKS*24` reads as zero, and a write to it changes nothing.
- R2: After reset, enable, mode and pending are all zero and sense is all ones. All status bits, bank requests and index valid flags are zero.
- R3: A line whose mode bit is 1 is edge sensing. With sense 1 it latches pending on a rising edge of its input; with sense 0 it latches on a falling edge. The pending bit is visible in status at the third clock edge after the input changes, and it stays set after the input returns.
- R4: A line whose mode bit is 0 is level sensing. Its status bit is 1 while the input equals its sense bit (1 means high, 0 means low). Acknowledging the line while the input stays active leaves the status bit at 1.
- R5: Writing 1 to an acknowledge bit clears that line's pending state. Writing 0 to an acknowledge bit changes nothing.
- R6: Writing 1 to a raise bit makes that line pending in either mode, until it is acknowledged. Writing 0 to a raise bit changes nothing. The raise and acknowledge registers read as zero.
- R7: `bank_irq[b]` is 1 exactly when some status bit of bank `b` is 1 and its enable bit is 1. A disabled line never drives the bank request.
- R8: `top_idx[b*5 +: 5]` gives the highest-numbered line of bank `b` that is both active in status and enabled, and `top_vld[b]` is 1. When no such line exists, `top_vld[b]` is 0 and the index is 0.
- R9: If an edge event and an acknowledge of the same line fall on the same clock edge, the line remains pending.
- R10: The banks are independent. A write to one bank, or input activity in one bank, does not alter the registers or outputs of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_BANKS*32 | Raw interrupt lines; line `l` of bank `b` is bit `b*32+l` |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| bank_irq | output | NUM_BANKS | Per-bank summary request |
| top_idx | output | NUM_BANKS*5 | Per-bank highest enabled active line number |
| top_vld | output | NUM_BANKS | Per-bank index valid |

## Verification
Two operations can land on the same pending bit in the same clock edge: an edge event that latches the line, and a software acknowledge that clears it. The bench provokes this by first leaving a line pending. It then lowers and raises the line again, and times an acknowledge write so that the write lands exactly on the third clock edge after the new rising edge. The design is judged correct only if the line still reads pending afterwards. A second acknowledge, made with no event in the same cycle, must then clear the line. This shows that the first survival came from the collision rule and not from an acknowledge that does nothing.

// File: rtl/bictl_pkg.sv
package bictl_pkg;
  localparam int unsigned LINES  = 32;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned STRIDE = 24;

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_ENA  = 3'd1,
    SEL_RAISE = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_SENSE = 3'd4,
    SEL_MODE = 3'd5
  } sel_e;

  // which bank a byte address falls in
  function automatic logic [31:0] bank_of(input logic [31:0] a);
    return a / STRIDE;
  endfunction

  // which register inside the bank (word granular)
  function automatic sel_e sel_of(input logic [31:0] a);
    logic [31:0] r;
    r = (a % STRIDE) >> 2;
    return sel_e'(r[2:0]);
  endfunction

  // number of the highest set bit; 0 when none
  function automatic logic [IDX_W-1:0] top_bit(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] n;
    n = '0;
    for (int i = 0; i < int'(LINES); i++)
      if (v[i]) n = IDX_W'(i);
    return n;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import bictl_pkg::*;
(
  input  logic [LINES-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    vld = |vec;
    idx = top_bit(vec);
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import bictl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_s,
  input  logic             wr_en,
  input  sel_e             sel,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_data,
  output logic             irq,
  output logic [IDX_W-1:0] idx,
  output logic             idx_vld
);
  logic [LINES-1:0] en_q, sense_q, mode_q, pend_q, prev_q;
  logic [LINES-1:0] qual_now, qual_prev, evt_vec, raise_vec, ack_vec;
  logic [LINES-1:0] pend_nxt, status, act;

  always_comb begin
    qual_now  = ~(line_s ^ sense_q);
    qual_prev = ~(prev_q ^ sense_q);
    evt_vec   = mode_q & qual_now & ~qual_prev;
    raise_vec = (wr_en && sel == SEL_RAISE) ? wdata : '0;
    ack_vec   = (wr_en && sel == SEL_ACK)   ? wdata : '0;
    // a fresh event outranks an acknowledge landing on the same edge
    pend_nxt  = (pend_q & ~ack_vec) | raise_vec | evt_vec;
    status    = pend_q | (~mode_q & qual_now);
    act       = status & en_q;
    irq       = |act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '1;
      mode_q  <= '0;
      pend_q  <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= line_s;
      pend_q <= pend_nxt;
      if (wr_en) begin
        case (sel)
          SEL_ENA:   en_q    <= wdata;
          SEL_SENSE: sense_q <= wdata;
          SEL_MODE:  mode_q  <= wdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT:  rd_data = status;
      SEL_ENA:   rd_data = en_q;
      SEL_SENSE: rd_data = sense_q;
      SEL_MODE:  rd_data = mode_q;
      default:   rd_data = '0;
    endcase
  end

  irq_prio prio_i (.vec(act), .idx(idx), .vld(idx_vld));

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec))); // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec) |=> ((pend_q & $past(ack_vec & ~evt_vec & ~raise_vec)) == '0)); // R5
  AST_RAISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_vec) |=> ((pend_q & $past(raise_vec)) == $past(raise_vec))); // R6
  AST_IDX_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    idx_vld |-> ((act >> idx) == 32'd1)); // R8
  AST_IRQ_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq == idx_vld); // R7
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bictl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS*LINES-1:0]   irq_in,
  input  logic                         reg_en,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic [NUM_BANKS-1:0]         bank_irq,
  output logic [NUM_BANKS*IDX_W-1:0]   top_idx,
  output logic [NUM_BANKS-1:0]         top_vld
);
  localparam int unsigned SPAN = NUM_BANKS * STRIDE;

  logic [NUM_BANKS*LINES-1:0] line_s;
  logic [31:0] addr32, bank_n, rdata_n;
  logic        hit;
  sel_e        sel;
  logic [31:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_wr;

  irq_sync #(.W(NUM_BANKS*LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(line_s));

  always_comb begin
    addr32 = 32'(reg_addr);
    bank_n = bank_of(addr32);
    sel    = sel_of(addr32);
    hit    = addr32 < SPAN;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b] = reg_en && reg_we && hit && (bank_n == 32'(b));
    irq_bank bank_i (
      .clk(clk), .rst_n(rst_n),
      .line_s(line_s[b*LINES +: LINES]),
      .wr_en(bank_wr[b]), .sel(sel), .wdata(reg_wdata),
      .rd_data(bank_rd[b]),
      .irq(bank_irq[b]),
      .idx(top_idx[b*IDX_W +: IDX_W]),
      .idx_vld(top_vld[b]));
  end

  always_comb begin
    rdata_n = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++)
      if (hit && bank_n == 32'(b)) rdata_n = bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               reg_rdata <= '0;
    else if (reg_en && !reg_we) reg_rdata <= rdata_n;
  end

  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr)); // R10
  AST_MISS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bank_wr == '0)); // R1
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && !hit) |=> (reg_rdata == '0)); // R1
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;
  localparam int NB = 5;
  localparam int WD = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*32-1:0] irq_in = '0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NB-1:0] bank_irq, top_vld;
  logic [NB*5-1:0] top_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bank_irq(bank_irq), .top_idx(top_idx), .top_vld(top_vld));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = 8'(a); reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = 8'(a);
    @(negedge clk);
    d = reg_rdata; reg_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [4:0] idx_of(input int b);
    return top_idx[b*5 +: 5];
  endfunction

  initial begin
    #(WD * 5.0);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset values, R1 map
    chk("R2 bank_irq", 32'(bank_irq), 0);
    chk("R2 top_vld", 32'(top_vld), 0);
    for (int b = 0; b < NB; b++) begin
      rd(b*24 + 0, v);  chk("R2 status", v, 0);
      rd(b*24 + 4, v);  chk("R2 enable", v, 0);
      rd(b*24 + 16, v); chk("R2 sense", v, 32'hFFFF_FFFF);
      rd(b*24 + 20, v); chk("R2 mode", v, 0);
    end
    // R1/R10 distinct banks
    for (int b = 0; b < NB; b++) wr(b*24 + 20, 32'h0101_0101 * (b + 1));
    for (int b = 0; b < NB; b++) begin
      rd(b*24 + 20, v); chk("R10 bank mode readback", v, 32'h0101_0101 * (b + 1));
    end
    wr(NB*24 + 4, 32'hFFFF_FFFF);
    rd(NB*24 + 4, v); chk("R1 unmapped read", v, 0);
    chk("R1 unmapped write", 32'(bank_irq), 0);
    for (int b = 0; b < NB; b++) wr(b*24 + 20, 0);

    // trigger mode sweep: R3 R4 R5 R7 R8 R10
    for (int b = 0; b < NB; b++) begin
      for (int ll = 0; ll < 36; ll += 5) begin
        int l;
        l = (ll > 31) ? 31 : ll;
        for (int m = 0; m < 4; m++) begin
          bit edg, pol;
          logic [31:0] bit_m;
          edg = m[1]; pol = m[0];
          bit_m = 32'd1 << l;
          irq_in[b*32 + l] = ~pol;
          wr(b*24 + 16, pol ? 32'hFFFF_FFFF : ~bit_m);
          wr(b*24 + 20, edg ? bit_m : 0);
          wr(b*24 + 4, bit_m);
          settle();
          wr(b*24 + 12, bit_m);
          rd(b*24, v); chk(edg ? "R3 idle status" : "R4 idle status", v, 0);
          chk("R7 idle irq", 32'(bank_irq), 0);
          irq_in[b*32 + l] = pol;
          settle();
          rd(b*24, v); chk(edg ? "R3 active status" : "R4 active status", v, bit_m);
          chk("R7 R10 bank irq", 32'(bank_irq), 32'd1 << b);
          chk("R8 idx", 32'(idx_of(b)), l);
          chk("R8 vld", 32'(top_vld), 32'd1 << b);
          if (!edg) begin
            wr(b*24 + 12, bit_m);
            rd(b*24, v); chk("R4 ack while active", v, bit_m);
          end
          irq_in[b*32 + l] = ~pol;
          settle();
          rd(b*24, v); chk(edg ? "R3 sticky" : "R4 live drop", v, edg ? bit_m : 0);
          if (edg) begin
            wr(b*24 + 12, bit_m);
            rd(b*24, v); chk("R5 ack clears", v, 0);
          end
          wr(b*24 + 16, 32'hFFFF_FFFF);
          irq_in[b*32 + l] = 1'b0;
          settle();
          wr(b*24 + 20, 0);
          wr(b*24 + 4, 0);
          wr(b*24 + 12, 32'hFFFF_FFFF);
        end
      end
    end

    // raise / ack / index sweep: R5 R6 R7 R8
    for (int b = 0; b < NB; b++) begin
      wr(b*24 + 4, 32'hFFFF_FFFF);
      for (int l = 0; l < 32; l++) begin
        wr(b*24 + 8, 32'd1 << l);
        chk("R6 R8 idx after raise", 32'(idx_of(b)), l);
      end
      rd(b*24, v);      chk("R6 all raised", v, 32'hFFFF_FFFF);
      rd(b*24 + 8, v);  chk("R6 raise reads zero", v, 0);
      rd(b*24 + 12, v); chk("R6 ack reads zero", v, 0);
      wr(b*24 + 12, 0);
      rd(b*24, v);      chk("R5 ack zero no effect", v, 32'hFFFF_FFFF);
      wr(b*24 + 4, 0);
      chk("R7 masked irq", 32'(bank_irq), 0);
      chk("R8 masked vld", 32'(top_vld), 0);
      chk("R8 masked idx", 32'(idx_of(b)), 0);
      wr(b*24 + 4, 32'hFFFF_FFFF);
      for (int l = 31; l > 0; l--) begin
        wr(b*24 + 12, 32'd1 << l);
        chk("R5 R8 idx after ack", 32'(idx_of(b)), l - 1);
      end
      wr(b*24 + 12, 1);
      chk("R8 empty vld", 32'(top_vld), 0);
      chk("R7 empty irq", 32'(bank_irq), 0);
      wr(b*24 + 8, 0);
      rd(b*24, v); chk("R6 raise zero no effect", v, 0);
      wr(b*24 + 4, 0);
    end

    // R9 edge event colliding with ack
    wr(24 + 20, 32'h10);
    wr(24 + 4, 32'h10);
    irq_in[32 + 4] = 1; settle();
    irq_in[32 + 4] = 0; settle();
    rd(24, v); chk("R9 pending before", v, 32'h10);
    irq_in[32 + 4] = 1;
    @(negedge clk);
    wr(24 + 12, 32'h10);
    rd(24, v); chk("R9 collision keeps pending", v, 32'h10);
    wr(24 + 12, 32'h10);
    rd(24, v); chk("R9 later ack clears", v, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule